// File: doc/BRIEF.md
# Dynamic Bit-Depth Expander

This block widens each of three colour components from 8 or 10 significant bits to a 12-bit word before the pixel reaches later processing. A mode input picks the source depth. The block does not pad the new low bits with zeros. It fills them with a copy of the component's own most significant bits, so that full scale stays full scale and black stays black after the widening.

Filling is allowed only when the outgoing link is HDMI or DisplayPort, in either single-stream or multi-stream form. A 3-bit link-kind code carries that qualifier. For any other link, or when the enable input is low, the component is left-justified in the 12-bit word and the new low bits are zero. A 12-bit source is handled as mode 0 with the enable set: its ten top bits are presented, and the two lowest bits are filled from the top instead of staying at zero.

Data and a valid flag pass through one register stage.

Top module: `bitdepth_expander`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first clock after it, out_valid is 0 and all three output components are 0.
- R2: out_valid equals the in_valid value sampled on the previous clock edge.
- R3: When filling is active and exp_mode is 1, each output is {x[7:0], x[7:4]}, where x is that component's 10-bit input.
- R4: When filling is active and exp_mode is 0, each output is {x[9:0], x[9:8]}.
- R5: Filling is active only when exp_en is 1 and link_kind is 1 (HDMI), 2 (DisplayPort single-stream) or 3 (DisplayPort multi-stream). Codes 0 and 4 to 7 disable it.
- R6: When filling is inactive, mode 1 gives {x[7:0], 4'b0000} and mode 0 gives {x[9:0], 2'b00}.
- R7: In mode 1, input bits [9:8] have no effect on the output.
- R8: When in_valid is low, the output components keep their previous values on the next clock.
- R9: Red, green and blue follow the same rule independently of one another, using the mode and qualifier of their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_en | input | 1 | Expansion enable |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source |
| link_kind | input | 3 | Link code: 1 HDMI, 2 DP single-stream, 3 DP multi-stream, other values are other links |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 10 | Red component, right-aligned |
| in_g | input | 10 | Green component, right-aligned |
| in_b | input | 10 | Blue component, right-aligned |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red component, 12 bits |
| out_g | output | 12 | Green component, 12 bits |
| out_b | output | 12 | Blue component, 12 bits |

## Verification
The assertions assume that every input holds a known 0 or 1 during reset, because the fill and hold properties compare against the values captured in the cycle before. The bench drives every input to a defined value from time zero and changes inputs only on the falling clock edge. The fill properties also read the mode and qualifier captured with the pixel. For that reason the stimulus changes exp_mode and link_kind only together with a new pixel, and never independently of the registered data it describes.

// File: rtl/bdx_pkg.sv
package bdx_pkg;
  localparam int OUT_W    = 12;
  localparam int WIDE_W   = 10;
  localparam int NARROW_W = 8;
  localparam int N_COMP   = 3;
  localparam int LINK_W   = 3;

  typedef enum logic [LINK_W-1:0] {
    LINK_OTHER  = 3'd0,
    LINK_HDMI   = 3'd1,
    LINK_DP_SST = 3'd2,
    LINK_DP_MST = 3'd3
  } link_kind_e;

  // Places a W-bit value at the top of an OUT_W word. When fill is set, the
  // vacated bits repeat the value's MSBs cyclically; otherwise they are zero.
  function automatic logic [OUT_W-1:0] widen(input logic [WIDE_W-1:0] x,
                                             input int w, input logic fill);
    logic [OUT_W-1:0] r;
    for (int i = 0; i < OUT_W; i++) begin
      if (i < w)
        r[OUT_W-1-i] = x[w-1-i];
      else
        r[OUT_W-1-i] = fill ? x[w-1-((i-w) % w)] : 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/bdx_qualify.sv
module bdx_qualify
  import bdx_pkg::*;
(
  input  logic              en,
  input  logic [LINK_W-1:0] kind,
  output logic              fill_on
);
  logic link_ok;
  always_comb begin
    unique case (kind)
      LINK_HDMI, LINK_DP_SST, LINK_DP_MST: link_ok = 1'b1;
      default:                             link_ok = 1'b0;
    endcase
  end
  assign fill_on = en & link_ok;
endmodule

// File: rtl/bdx_lane.sv
module bdx_lane
  import bdx_pkg::*;
(
  input  logic [WIDE_W-1:0] comp_in,
  input  logic              narrow,
  input  logic              fill_on,
  output logic [OUT_W-1:0]  comp_out
);
  logic [OUT_W-1:0] from_wide, from_narrow;
  assign from_wide   = widen(comp_in, WIDE_W, fill_on);
  assign from_narrow = widen({{(WIDE_W-NARROW_W){1'b0}}, comp_in[NARROW_W-1:0]},
                             NARROW_W, fill_on);
  assign comp_out    = narrow ? from_narrow : from_wide;
endmodule

// File: rtl/bitdepth_expander.sv
module bitdepth_expander
  import bdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exp_en,
  input  logic              exp_mode,
  input  logic [2:0]        link_kind,
  input  logic              in_valid,
  input  logic [9:0]        in_r,
  input  logic [9:0]        in_g,
  input  logic [9:0]        in_b,
  output logic              out_valid,
  output logic [11:0]       out_r,
  output logic [11:0]       out_g,
  output logic [11:0]       out_b
);
  localparam int FILL_WIDE   = OUT_W - WIDE_W;
  localparam int FILL_NARROW = OUT_W - NARROW_W;

  logic                               fill_on;
  logic [N_COMP-1:0][WIDE_W-1:0]      comp_in;
  logic [N_COMP-1:0][OUT_W-1:0]       comp_next;
  logic [N_COMP-1:0][OUT_W-1:0]       comp_q;
  // captured per pixel, for the checks
  logic                               cap_fill, cap_narrow;

  assign comp_in = {in_b, in_g, in_r};

  bdx_qualify u_qual (.en(exp_en), .kind(link_kind), .fill_on(fill_on));

  for (genvar c = 0; c < N_COMP; c++) begin : g_lane
    bdx_lane u_lane (
      .comp_in (comp_in[c]),
      .narrow  (exp_mode),
      .fill_on (fill_on),
      .comp_out(comp_next[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      comp_q     <= '0;
      cap_fill   <= 1'b0;
      cap_narrow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        comp_q     <= comp_next;
        cap_fill   <= fill_on;
        cap_narrow <= exp_mode;
      end
    end
  end

  assign out_r = comp_q[0];
  assign out_g = comp_q[1];
  assign out_b = comp_q[2];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(comp_q));

  for (genvar c = 0; c < N_COMP; c++) begin : g_chk
    a_r3_narrow_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cap_fill && cap_narrow) |->
        comp_q[c][FILL_NARROW-1:0] == comp_q[c][OUT_W-1 -: FILL_NARROW]);
    a_r4_wide_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cap_fill && !cap_narrow) |->
        comp_q[c][FILL_WIDE-1:0] == comp_q[c][OUT_W-1 -: FILL_WIDE]);
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cap_fill) |->
        (cap_narrow ? comp_q[c][FILL_NARROW-1:0] == '0
                    : comp_q[c][FILL_WIDE-1:0] == '0));
  end
endmodule

// File: tb/test_bitdepth_expander.sv
module test_bitdepth_expander;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exp_en = 1'b0, exp_mode = 1'b0, in_valid = 1'b0;
  logic [2:0] link_kind = 3'd0;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid;
  logic [11:0] out_r, out_g, out_b;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bitdepth_expander i_bitdepth_expander (
    .clk(clk), .rst_n(rst_n), .exp_en(exp_en), .exp_mode(exp_mode),
    .link_kind(link_kind), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  // en, mode, link, r, g, b
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd1, 10'h0AB, 10'h0FF, 10'h000},
    {1'b1, 1'b0, 3'd1, 10'h2C5, 10'h3FF, 10'h001},
    {1'b1, 1'b1, 3'd2, 10'h381, 10'h17E, 10'h200},
    {1'b1, 1'b0, 3'd3, 10'h155, 10'h2AA, 10'h100},
    {1'b0, 1'b1, 3'd1, 10'h0C3, 10'h3FF, 10'h012},
    {1'b0, 1'b0, 3'd2, 10'h3FF, 10'h201, 10'h0F0},
    {1'b1, 1'b1, 3'd0, 10'h0FF, 10'h080, 10'h07F},
    {1'b1, 1'b0, 3'd4, 10'h3FF, 10'h123, 10'h321},
    {1'b1, 1'b0, 3'd7, 10'h2D2, 10'h0E1, 10'h3C0},
    {1'b1, 1'b1, 3'd3, 10'h3A5, 10'h05A, 10'h2FF}
  };

  function automatic logic [11:0] model(logic [9:0] x, logic en, logic md,
                                        logic [2:0] lk);
    logic on;
    logic [11:0] v;
    on = en && (lk == 3'd1 || lk == 3'd2 || lk == 3'd3);
    if (md) begin
      v = {4'h0, x[7:0]};
      return on ? ((v << 4) | (v >> 4)) : (v << 4);
    end
    v = {2'b00, x};
    return on ? ((v << 2) | (v >> 8)) : (v << 2);
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic drive(logic v, logic en, logic md, logic [2:0] lk,
                       logic [9:0] r, logic [9:0] g, logic [9:0] b);
    @(negedge clk);
    in_valid = v; exp_en = en; exp_mode = md; link_kind = lk;
    in_r = r; in_g = g; in_b = b;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] er, eg, eb;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 valid", {11'b0, out_valid}, 12'h000);
    check("R1 r", out_r, 12'h000);
    check("R1 g", out_g, 12'h000);
    check("R1 b", out_b, 12'h000);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VEC[k][34], VEC[k][33], VEC[k][32:30],
            VEC[k][29:20], VEC[k][19:10], VEC[k][9:0]);
      check("R2 valid", {11'b0, out_valid}, 12'h001);
      check("R3/R4/R5/R6 r", out_r,
            model(VEC[k][29:20], VEC[k][34], VEC[k][33], VEC[k][32:30]));
      check("R9 g", out_g,
            model(VEC[k][19:10], VEC[k][34], VEC[k][33], VEC[k][32:30]));
      check("R9 b", out_b,
            model(VEC[k][9:0], VEC[k][34], VEC[k][33], VEC[k][32:30]));
    end

    // R3 explicit corners
    drive(1'b1, 1'b1, 1'b1, 3'd1, 10'h0FF, 10'h000, 10'h080);
    check("R3 full scale", out_r, 12'hFFF);
    check("R3 black", out_g, 12'h000);
    check("R3 mid", out_b, 12'h808);

    // R4 explicit corners (12-bit source top bits in mode 0)
    drive(1'b1, 1'b1, 1'b0, 3'd2, 10'h3FF, 10'h200, 10'h001);
    check("R4 full scale", out_r, 12'hFFF);
    check("R4 msb", out_g, 12'h802);
    check("R4 lsb", out_b, 12'h004);

    // R7: bits 9:8 ignored in mode 1
    drive(1'b1, 1'b1, 1'b1, 3'd3, 10'h35A, 10'h05A, 10'h25A);
    check("R7 r", out_r, 12'h5A5);
    check("R7 g", out_g, 12'h5A5);
    check("R7 b", out_b, 12'h5A5);

    // R8: hold while invalid, even as inputs change
    er = out_r; eg = out_g; eb = out_b;
    drive(1'b0, 1'b0, 1'b0, 3'd0, 10'h111, 10'h222, 10'h333);
    check("R2 idle valid", {11'b0, out_valid}, 12'h000);
    check("R8 r", out_r, er);
    check("R8 g", out_g, eg);
    check("R8 b", out_b, eb);
    drive(1'b0, 1'b1, 1'b1, 3'd1, 10'h3FF, 10'h3FF, 10'h3FF);
    check("R8 r second", out_r, er);

    // R5: every link code with enable high, mode 0
    for (int lk = 0; lk < 8; lk++) begin
      drive(1'b1, 1'b1, 1'b0, 3'(lk), 10'h301, 10'h301, 10'h301);
      check("R5 link", out_r, (lk >= 1 && lk <= 3) ? 12'hC07 : 12'hC04);
    end

    // R1: reset mid-stream clears outputs
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R1 re-reset valid", {11'b0, out_valid}, 12'h000);
    check("R1 re-reset r", out_r, 12'h000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule